// File: doc/BRIEF.md
# Hierarchical Interrupt Controller with Automatic Enable Clearing

This controller gathers event pulses from several functional blocks, each carrying a small group of interrupt sources, plus a built-in one-second tick. Each source passes two gates before it can request service. The first is its own enable bit, which decides whether the event is captured at all. The second is the enable bit of its block, which decides whether captured causes reach the single active-low request line `irq_n`. Software reaches every control and status register through a flat byte-wide register bus. Reads take effect combinationally and their clearing side effects happen at the clock edge.

An optional mode guards against interrupt storms. Once a source has fired, its enable bit is withdrawn automatically, and software re-arms it later. The cause stays latched, so the handler can still read it. Block enable bits act only as gates. Setting one never turns on a source that is disabled at the source level. A writable soft-reset bit in the mode register returns every enable and status register to its idle value in one cycle.

Register map (byte addresses): mode register 0x00. Block enable 0x04, where bit b is block b and bit NBLK is the one-second tick. Block status 0x05, read-only, with the same bit layout. For block b, the source enable register is at 0x10+2b and the source status register at 0x11+2b. Source bit i of block b is event input bit b*NSRC+i.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_n` is 1.
- R2: `irq_n` is 0 exactly when some bit of the block status register at 0x05 and the same bit of the block enable register at 0x04 are both 1.
- R3: A source status bit is set only by an event on a source whose enable bit is 1. Events on disabled sources are never captured, whatever the block enable bit holds.
- R4: Reading a source status register returns its bits and clears them at that edge. An event captured in the same cycle is kept.
- R5: With mode bit 3 at 1, a source that captures an event has its enable bit cleared at the same edge. This clearing overrides a simultaneous write of 1, and the captured status stays set. With mode bit 3 at 0, enables are left unchanged.
- R6: Block status bit b reads as the OR of block b's source status bits. A block enable bit of 0 keeps that block off `irq_n` but does not hide or clear its status.
- R7: While block enable bit NBLK is 1, the one-second status bit is set every TICK_CYCLES cycles. The first setting comes TICK_CYCLES edges after the enabling write. The period counter is held at zero while the bit is 0.
- R8: Reading 0x05 clears the one-second status bit and no other. A tick in the same cycle keeps it set.
- R9: Writing the mode register with bit 4 at 1 clears all enable and status registers and the tick counter. The other mode bits take the written value, and bit 4 reads back as 0.
- R10: Mode bits other than bit 4 read back as written and are driven on `mode_cfg`.
- R11: Unmapped addresses read as 0x00, and writes to them or to status registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; clear-on-read effects at the edge |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| src_evt | input | NBLK*NSRC | Single-cycle event pulses from the source blocks |
| mode_cfg | output | 8 | Current mode register contents |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions take for granted that the bus never asserts read and write together, that event inputs are synchronous single-cycle pulses, and that TICK_CYCLES is at least 2. The tick-isolation and counter-range properties rely on that last point. The stimulus drives every input at the falling edge and releases strobes after one rising edge, so each operation lands on exactly one edge. Read, write and event are combined in the same cycle only where a requirement calls for that collision.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [7:0] ADR_MODE     = 8'h00;
  localparam logic [7:0] ADR_BLK_EN   = 8'h04;
  localparam logic [7:0] ADR_BLK_ST   = 8'h05;
  localparam logic [7:0] ADR_SRC_BASE = 8'h10;

  localparam int MODE_AUTO_DIS = 3;
  localparam int MODE_SOFT_RST = 4;

  function automatic logic [7:0] src_en_addr(input int blk);
    return ADR_SRC_BASE + 8'(2 * blk);
  endfunction

  function automatic logic [7:0] src_st_addr(input int blk);
    return ADR_SRC_BASE + 8'(2 * blk + 1);
  endfunction

  // active-low request: any pending cause whose gate is open
  function automatic logic irq_level(input logic [7:0] st, input logic [7:0] en);
    return ~|(st & en);
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic            auto_dis,
  input  logic [NSRC-1:0] evt,
  input  logic            en_wr,
  input  logic            st_rd,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] st_q,
  output logic            pend
);
  logic [NSRC-1:0] fire;
  logic [NSRC-1:0] en_d, st_d;

  assign fire = evt & en_q;
  assign pend = |st_q;

  always_comb begin
    en_d = en_wr ? wdata : en_q;
    if (auto_dis) en_d = en_d & ~fire;
    st_d = (st_rd ? '0 : st_q) | fire;
    if (soft_clr) begin
      en_d = '0;
      st_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  // R3: only enabled events may create new status bits
  a_r3_no_latch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(fire)) == '0));

  // R4: a captured event survives a simultaneous clearing read
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire && !soft_clr) |=> ((st_q & $past(fire)) == $past(fire)));

  // R5: automatic mode withdraws the enable of a source that fired
  a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_dis && |fire) |=> ((en_q & $past(fire)) == '0));
endmodule

// File: rtl/irq_sec_timer.sv
module irq_sec_timer #(
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr || !run)   cnt_q <= '0;
    else if (tick)          cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R7: ticks are isolated single-cycle pulses
  a_r7_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7: the counter never runs past one period
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NBLK        = 2,
  parameter int NSRC        = 4,
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [7:0]           bus_rdata,
  input  logic [NBLK*NSRC-1:0] src_evt,
  output logic [7:0]           mode_cfg,
  output logic                 irq_n
);
  localparam int SEC_BIT = NBLK;
  localparam int BW      = NBLK + 1;

  logic [7:0]    mode_q;
  logic [BW-1:0] blk_en_q;
  logic [BW-1:0] blk_st;
  logic          sec_st_q;
  logic          sec_tick;
  logic          soft_clr;
  logic          blk_st_rd;

  logic [NBLK-1:0][NSRC-1:0] bank_en, bank_st;
  logic [NBLK-1:0]           bank_pend;

  assign soft_clr  = bus_wr && (bus_addr == ADR_MODE) && bus_wdata[MODE_SOFT_RST];
  assign blk_st_rd = bus_rd && (bus_addr == ADR_BLK_ST);
  assign mode_cfg  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      blk_en_q <= '0;
      sec_st_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADR_MODE)
        mode_q <= bus_wdata & ~(8'h01 << MODE_SOFT_RST);
      if (soft_clr)
        blk_en_q <= '0;
      else if (bus_wr && bus_addr == ADR_BLK_EN)
        blk_en_q <= bus_wdata[BW-1:0];
      if (soft_clr)       sec_st_q <= 1'b0;
      else if (sec_tick)  sec_st_q <= 1'b1;
      else if (blk_st_rd) sec_st_q <= 1'b0;
    end
  end

  irq_sec_timer #(.TICK_CYCLES(TICK_CYCLES)) u_sec (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (blk_en_q[SEC_BIT]),
    .clr  (soft_clr),
    .tick (sec_tick)
  );

  for (genvar b = 0; b < NBLK; b++) begin : g_bank
    irq_src_bank #(.NSRC(NSRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_clr(soft_clr),
      .auto_dis(mode_q[MODE_AUTO_DIS]),
      .evt     (src_evt[b*NSRC +: NSRC]),
      .en_wr   (bus_wr && bus_addr == src_en_addr(b)),
      .st_rd   (bus_rd && bus_addr == src_st_addr(b)),
      .wdata   (bus_wdata[NSRC-1:0]),
      .en_q    (bank_en[b]),
      .st_q    (bank_st[b]),
      .pend    (bank_pend[b])
    );
    assign blk_st[b] = bank_pend[b];
  end
  assign blk_st[SEC_BIT] = sec_st_q;

  assign irq_n = irq_level(8'(blk_st), 8'(blk_en_q));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_MODE)   bus_rdata = mode_q;
    if (bus_addr == ADR_BLK_EN) bus_rdata[BW-1:0] = blk_en_q;
    if (bus_addr == ADR_BLK_ST) bus_rdata[BW-1:0] = blk_st;
    for (int b = 0; b < NBLK; b++) begin
      if (bus_addr == src_en_addr(b)) bus_rdata[NSRC-1:0] = bank_en[b];
      if (bus_addr == src_st_addr(b)) bus_rdata[NSRC-1:0] = bank_st[b];
    end
  end

  // R6: with every block gate closed the request line stays idle
  a_r6_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en_q == '0) |-> irq_n);

  // R8: a clearing read with no competing tick drops the one-second cause
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_st_rd && !sec_tick) |=> !sec_st_q);

  // R8: a tick always leaves the one-second cause pending
  a_r8_tick_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !soft_clr) |=> sec_st_q);

  // R9: soft reset leaves gates closed, causes cleared and its own bit low
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (blk_en_q == '0 && !sec_st_q && !mode_q[MODE_SOFT_RST] && irq_n));
endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  localparam int NBLK = 2;
  localparam int NSRC = 4;
  localparam int TICK = 16;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] src_evt = '0;
  logic [7:0] mode_cfg;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_hub #(.NBLK(NBLK), .NSRC(NSRC), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_evt(src_evt), .mode_cfg(mode_cfg), .irq_n(irq_n)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] adr;
    logic [7:0] dat;
    logic [7:0] evt;
    logic [7:0] exp_rd;
    logic       exp_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 4'd1},  // R1 mode reset
    '{OP_RD,   8'h04, 8'h00, 8'h00, 8'h00, 1'b1, 4'd1},  // R1 block enable reset
    '{OP_WR,   8'h10, 8'h05, 8'h00, 8'h00, 1'b1, 4'd3},  // enable src0,src2 of block 0
    '{OP_IDLE, 8'h00, 8'h00, 8'h02, 8'h00, 1'b1, 4'd3},  // disabled src1 fires
    '{OP_RD,   8'h11, 8'h00, 8'h00, 8'h00, 1'b1, 4'd3},  // R3 nothing latched
    '{OP_IDLE, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 4'd6},  // src0 latched, block gate closed
    '{OP_RD,   8'h05, 8'h00, 8'h00, 8'h01, 1'b1, 4'd6},  // R6 status visible while masked
    '{OP_WR,   8'h04, 8'h01, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 open block 0 gate
    '{OP_RD,   8'h11, 8'h00, 8'h00, 8'h01, 1'b1, 4'd4},  // R4 read clears
    '{OP_IDLE, 8'h00, 8'h00, 8'h04, 8'h00, 1'b0, 4'd2},  // src2 fires
    '{OP_RD,   8'h11, 8'h00, 8'h01, 8'h04, 1'b0, 4'd4},  // R4 event with read kept
    '{OP_RD,   8'h11, 8'h00, 8'h00, 8'h01, 1'b1, 4'd4},
    '{OP_RD,   8'h10, 8'h00, 8'h00, 8'h05, 1'b1, 4'd5},  // R5 enables kept, auto off
    '{OP_WR,   8'h00, 8'h08, 8'h00, 8'h00, 1'b1, 4'd5},  // auto mode on
    '{OP_RD,   8'h00, 8'h00, 8'h00, 8'h08, 1'b1, 4'd10},
    '{OP_IDLE, 8'h00, 8'h00, 8'h04, 8'h00, 1'b0, 4'd5},  // src2 fires, enable drops
    '{OP_RD,   8'h10, 8'h00, 8'h00, 8'h01, 1'b0, 4'd5},  // R5 enable cleared, irq held
    '{OP_RD,   8'h11, 8'h00, 8'h00, 8'h04, 1'b1, 4'd5},  // R5 cause still readable
    '{OP_IDLE, 8'h00, 8'h00, 8'h04, 8'h00, 1'b1, 4'd3},  // auto-disabled src fires again
    '{OP_RD,   8'h11, 8'h00, 8'h00, 8'h00, 1'b1, 4'd3},
    '{OP_WR,   8'h12, 8'h0F, 8'h00, 8'h00, 1'b1, 4'd3},  // block 1 all sources on
    '{OP_IDLE, 8'h00, 8'h00, 8'h30, 8'h00, 1'b1, 4'd6},  // block 1 src0,src1 fire, masked
    '{OP_RD,   8'h05, 8'h00, 8'h00, 8'h02, 1'b1, 4'd6},
    '{OP_WR,   8'h04, 8'h03, 8'h00, 8'h00, 1'b0, 4'd2},
    '{OP_RD,   8'h12, 8'h00, 8'h00, 8'h0C, 1'b0, 4'd5},
    '{OP_WR,   8'h12, 8'h0F, 8'h40, 8'h00, 1'b0, 4'd5},  // R5 auto-clear beats write
    '{OP_RD,   8'h12, 8'h00, 8'h00, 8'h0B, 1'b0, 4'd5},
    '{OP_RD,   8'h13, 8'h00, 8'h00, 8'h07, 1'b1, 4'd4},
    '{OP_WR,   8'h7F, 8'hFF, 8'h00, 8'h00, 1'b1, 4'd11}, // R11 unmapped write
    '{OP_WR,   8'h05, 8'hFF, 8'h00, 8'h00, 1'b1, 4'd11}, // R11 status write ignored
    '{OP_RD,   8'h7F, 8'h00, 8'h00, 8'h00, 1'b1, 4'd11}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // one operation = one rising edge; called and returning at a falling edge
  task automatic bus_op(input logic [1:0] op, input logic [7:0] adr, input logic [7:0] dat,
                        input logic [7:0] evt, input logic [7:0] exp_rd,
                        input logic exp_irq, input string req);
    bus_addr  = adr;
    bus_wdata = dat;
    bus_wr    = (op == OP_WR);
    bus_rd    = (op == OP_RD);
    src_evt   = evt;
    #1;
    if (op == OP_RD) chk({req, " rdata"}, bus_rdata, exp_rd);
    @(posedge clk);
    #1;
    chk({req, " irq_n"}, {7'd0, irq_n}, {7'd0, exp_irq});
    @(negedge clk);
    bus_wr  = 1'b0;
    bus_rd  = 1'b0;
    src_evt = '0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq_n idle in reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode_cfg", mode_cfg, 8'h00);

    for (int i = 0; i < NV; i++)
      bus_op(VECS[i].op, VECS[i].adr, VECS[i].dat, VECS[i].evt,
             VECS[i].exp_rd, VECS[i].exp_irq, $sformatf("R%0d vec%0d", VECS[i].req, i));
    bus_op(OP_RD, 8'h04, 8'h00, 8'h00, 8'h03, 1'b1, "R11 enable unchanged");
    bus_op(OP_WR, 8'h04, 8'h00, 8'h00, 8'h00, 1'b1, "R2 close gates");

    // R7: one-second tick, first after TICK edges
    bus_op(OP_WR, 8'h04, 8'h04, 8'h00, 8'h00, 1'b1, "R7 enable tick");
    for (int k = 1; k < TICK; k++)
      bus_op(OP_IDLE, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R7 before tick");
    bus_op(OP_IDLE, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R7 first tick");
    bus_op(OP_RD, 8'h05, 8'h00, 8'h00, 8'h04, 1'b1, "R8 read clears tick");
    for (int k = 2; k < TICK; k++)
      bus_op(OP_IDLE, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R7 between ticks");
    bus_op(OP_RD, 8'h05, 8'h00, 8'h00, 8'h00, 1'b0, "R8 tick beats read");
    bus_op(OP_RD, 8'h05, 8'h00, 8'h00, 8'h04, 1'b1, "R8 second read");

    // R9: soft reset with causes pending
    bus_op(OP_WR, 8'h10, 8'h01, 8'h00, 8'h00, 1'b1, "R9 setup");
    bus_op(OP_WR, 8'h04, 8'h05, 8'h01, 8'h00, 1'b0, "R9 setup pending");
    bus_op(OP_WR, 8'h00, 8'h18, 8'h00, 8'h00, 1'b1, "R9 soft reset");
    bus_op(OP_RD, 8'h00, 8'h00, 8'h00, 8'h08, 1'b1, "R9 mode bit4 clear");
    bus_op(OP_RD, 8'h04, 8'h00, 8'h00, 8'h00, 1'b1, "R9 block enable");
    bus_op(OP_RD, 8'h10, 8'h00, 8'h00, 8'h00, 1'b1, "R9 source enable");
    bus_op(OP_RD, 8'h11, 8'h00, 8'h00, 8'h00, 1'b1, "R9 source status");
    bus_op(OP_RD, 8'h05, 8'h00, 8'h00, 8'h00, 1'b1, "R9 block status");

    // R10: mode readback and output
    bus_op(OP_WR, 8'h00, 8'hE7, 8'h00, 8'h00, 1'b1, "R10 write mode");
    bus_op(OP_RD, 8'h00, 8'h00, 8'h00, 8'hE7, 1'b1, "R10 read mode");
    chk("R10 mode_cfg", mode_cfg, 8'hE7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule